// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits on the device side of a word-wide parallel NOR flash and interprets the stream of host write cycles. Each write has an address, a 16-bit data value and a write strobe. The block recognises the two-write unlock handshake and the command code that follows it. It tracks the device mode: read array, autoselect, unlock bypass, sector erase running, or erase suspended. When a sequence completes, it fires a one-clock start pulse for a program, a sector erase or a chip erase, and latches the address and data of the final write for the engine that carries out the operation.

The block also steers the read path. In autoselect mode, reads return identification or sector-protection data instead of array contents. An external busy input, driven by the program and erase engine, blocks new commands while an operation is running. The only exceptions are erase suspend and erase resume during a sector erase.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), all three start pulses are low, and `rd_data` equals `array_rdata`.
- R2: During unlock and command cycles, only `wr_addr[10:0]` and `wr_data[7:0]` are compared, so address bits 18..11 and data bits 15..8 have no effect. The unlock writes are 0xAA at 0x555 and then 0x55 at 0x2AA.
- R3: Unlock, then 0xA0 at 0x555, then one further write produces a one-clock `prog_start`. `op_addr` and `op_data` hold that final write, and the mode afterwards is 0.
- R4: Unlock followed by 0x90 at 0x555 sets `mode` to 1 (autoselect). In mode 0 or 1, a single write whose low data byte is 0xF0, at any address, sets `mode` to 0.
- R5: In mode 1, `rd_data` depends on `rd_addr[7:0]`. Offset 0x01 returns 0x225B. Offset 0x02 returns `sector_prot[rd_addr[18:12]]`, zero-extended. Any other offset returns 0. In every other mode, `rd_data` equals `array_rdata`.
- R6: Unlock, 0x80 at 0x555, a second unlock, then 0x10 at 0x555 produces a one-clock `chip_erase_start`.
- R7: The same six-write prefix ending with 0x30 at any address produces a one-clock `sect_erase_start` with `op_addr` equal to that address, and `mode` becomes 3 (sector erase running).
- R8: Unlock then 0x20 at 0x555 sets `mode` to 2 (unlock bypass). In mode 2, 0xA0 at any address followed by one write produces `prog_start` and leaves the mode at 2. A write of 0x90 followed by 0x00 returns the mode to 0. A write of 0x90 followed by anything else leaves the mode at 2.
- R9: A write that does not match the expected next step of a standard sequence abandons the sequence without any pulse, and sets `mode` to 0. Any later command needs a full unlock.
- R10: While `busy` is high in modes 0, 1 or 2, writes are ignored: no pulse and no change of mode.
- R11: A write of 0xB0 changes the mode from 3 to 4 (suspended), and has no effect in any other mode. A write of 0x30 in mode 4 returns the mode to 3. In mode 3, a cycle with `busy` low and no suspend write returns the mode to 0.
- R12: The start pulses last exactly one clock and never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 19 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Program/erase engine running |
| rd_addr | input | 19 | Word address of the current read |
| array_rdata | input | 16 | Data from the memory array |
| sector_prot | input | 128 | Protection flag for each sector |
| rd_data | output | 16 | Read data to the host |
| mode | output | 3 | 0 read, 1 autoselect, 2 bypass, 3 sector erase, 4 suspended |
| prog_start | output | 1 | One-clock program start |
| sect_erase_start | output | 1 | One-clock sector erase start |
| chip_erase_start | output | 1 | One-clock chip erase start |
| op_addr | output | 19 | Address latched with the start pulse |
| op_data | output | 16 | Data latched with the start pulse |

## Verification
The assertions assume that `busy` rises in the cycle after a sector erase pulse. They also assume it stays high while an erase is running or suspended, and that `wr_en` is a single-cycle strobe with stable address and data. The bench drives every write as one strobed cycle set up on the falling clock edge. It raises `busy` straight after each sector erase start and drops it only to end that erase. Reads are only observed through the combinational `rd_data`, with `rd_addr` held steady.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_AW = 11;

  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_BYPASS  = 3'd2,
    MODE_SERASE  = 3'd3,
    MODE_SUSPEND = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ER1,
    ST_ER2,
    ST_ER3,
    ST_BEXIT
  } step_e;

  localparam logic [CMD_AW-1:0] ADDR_CMD = 11'h555;
  localparam logic [CMD_AW-1:0] ADDR_ALT = 11'h2AA;
  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OP_AUTOSEL  = 8'h90;
  localparam logic [7:0] OP_PROG     = 8'hA0;
  localparam logic [7:0] OP_BYPASS   = 8'h20;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_RESUME   = 8'h30;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_BEXIT    = 8'h00;
endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_key1,
  output logic              hit_key2,
  output logic              at_cmd,
  output logic [7:0]        code
);
  logic [CMD_AW-1:0] low_addr;

  always_comb begin
    low_addr = wr_addr[CMD_AW-1:0];
    code     = wr_data[7:0];
    at_cmd   = (low_addr == ADDR_CMD);
    hit_key1 = at_cmd && (code == KEY_FIRST);
    hit_key2 = (low_addr == ADDR_ALT) && (code == KEY_SECOND);
  end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_key1,
  input  logic              hit_key2,
  input  logic              at_cmd,
  input  logic [7:0]        code,
  output mode_e             mode_o,
  output logic              prog_o,
  output logic              sect_o,
  output logic              chip_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  step_e step_q, step_d;
  mode_e mode_q, mode_d;
  logic  prog_q, prog_d, sect_q, sect_d, chip_q, chip_d;
  logic  lat_en;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;

  always_comb begin
    step_d = step_q;
    mode_d = mode_q;
    prog_d = 1'b0;
    sect_d = 1'b0;
    chip_d = 1'b0;
    lat_en = 1'b0;
    if (wr_en) begin
      case (mode_q)
        MODE_SERASE: begin
          if (code == OP_SUSPEND) mode_d = MODE_SUSPEND;
        end
        MODE_SUSPEND: begin
          if (code == OP_RESUME) mode_d = MODE_SERASE;
        end
        default: begin
          if (!busy) begin
            case (step_q)
              ST_IDLE: begin
                if (mode_q == MODE_BYPASS) begin
                  if (code == OP_PROG)          step_d = ST_PROG;
                  else if (code == OP_AUTOSEL)  step_d = ST_BEXIT;
                end else if (hit_key1) begin
                  step_d = ST_UNL1;
                end else if (code == OP_RESET) begin
                  mode_d = MODE_READ;
                end
              end
              ST_UNL1: begin
                step_d = hit_key2 ? ST_UNL2 : ST_IDLE;
                if (!hit_key2) mode_d = MODE_READ;
              end
              ST_UNL2: begin
                step_d = ST_IDLE;
                if (at_cmd && code == OP_AUTOSEL)     mode_d = MODE_AUTOSEL;
                else if (at_cmd && code == OP_PROG)   step_d = ST_PROG;
                else if (at_cmd && code == OP_BYPASS) mode_d = MODE_BYPASS;
                else if (at_cmd && code == OP_ERASE)  step_d = ST_ER1;
                else                                  mode_d = MODE_READ;
              end
              ST_PROG: begin
                prog_d = 1'b1;
                lat_en = 1'b1;
                step_d = ST_IDLE;
                if (mode_q != MODE_BYPASS) mode_d = MODE_READ;
              end
              ST_ER1: begin
                step_d = hit_key1 ? ST_ER2 : ST_IDLE;
                if (!hit_key1) mode_d = MODE_READ;
              end
              ST_ER2: begin
                step_d = hit_key2 ? ST_ER3 : ST_IDLE;
                if (!hit_key2) mode_d = MODE_READ;
              end
              ST_ER3: begin
                step_d = ST_IDLE;
                if (at_cmd && code == OP_CHIP) begin
                  chip_d = 1'b1;
                  lat_en = 1'b1;
                  mode_d = MODE_READ;
                end else if (code == OP_SECTOR) begin
                  sect_d = 1'b1;
                  lat_en = 1'b1;
                  mode_d = MODE_SERASE;
                end else begin
                  mode_d = MODE_READ;
                end
              end
              ST_BEXIT: begin
                step_d = ST_IDLE;
                if (code == OP_BEXIT) mode_d = MODE_READ;
              end
              default: step_d = ST_IDLE;
            endcase
          end
        end
      endcase
    end
    if (mode_q == MODE_SERASE && !busy && !(wr_en && code == OP_SUSPEND))
      mode_d = MODE_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      mode_q <= MODE_READ;
      prog_q <= 1'b0;
      sect_q <= 1'b0;
      chip_q <= 1'b0;
    end else begin
      step_q <= step_d;
      mode_q <= mode_d;
      prog_q <= prog_d;
      sect_q <= sect_d;
      chip_q <= chip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (lat_en) begin
      op_addr_q <= wr_addr;
      op_data_q <= wr_data;
    end
  end

  assign mode_o    = mode_q;
  assign prog_o    = prog_q;
  assign sect_o    = sect_q;
  assign chip_o    = chip_q;
  assign op_addr_o = op_addr_q;
  assign op_data_o = op_data_q;

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_q, sect_q, chip_q}));

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q || sect_q || chip_q) |=> !(prog_q || sect_q || chip_q));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && (mode_q == MODE_READ || mode_q == MODE_AUTOSEL || mode_q == MODE_BYPASS))
      |=> (!(prog_q || sect_q || chip_q) && mode_q == $past(mode_q)));

  // R11
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SUSPEND && $past(mode_q) != MODE_SUSPEND) |-> $past(mode_q) == MODE_SERASE);

  // R7
  serase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_q |-> mode_q == MODE_SERASE);
endmodule

// File: rtl/nor_rd_sel.sv
module nor_rd_sel #(
  parameter int          ADDR_W   = 19,
  parameter int          DATA_W   = 16,
  parameter int          SECT_LSB = 12,
  parameter logic [15:0] DEV_ID   = 16'h225B,
  localparam int         NUM_SECT = 1 << (ADDR_W - SECT_LSB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                autosel,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   array_rdata,
  input  logic [NUM_SECT-1:0] sector_prot,
  output logic [DATA_W-1:0]   rd_data
);
  logic [7:0] offs;
  logic [ADDR_W-SECT_LSB-1:0] sect_idx;

  always_comb begin
    offs     = rd_addr[7:0];
    sect_idx = rd_addr[ADDR_W-1:SECT_LSB];
    rd_data  = array_rdata;
    if (autosel) begin
      if (offs == 8'h01)      rd_data = DATA_W'(DEV_ID);
      else if (offs == 8'h02) rd_data = DATA_W'(sector_prot[sect_idx]);
      else                    rd_data = '0;
    end
  end

  // R5
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autosel && rd_addr[7:0] == 8'h01) |-> rd_data == DATA_W'(DEV_ID));

  // R5
  array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !autosel |-> rd_data == array_rdata);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int  ADDR_W   = 19,
  parameter int  DATA_W   = 16,
  parameter int  SECT_LSB = 12,
  localparam int NUM_SECT = 1 << (ADDR_W - SECT_LSB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                busy,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   array_rdata,
  input  logic [NUM_SECT-1:0] sector_prot,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2:0]          mode,
  output logic                prog_start,
  output logic                sect_erase_start,
  output logic                chip_erase_start,
  output logic [ADDR_W-1:0]   op_addr,
  output logic [DATA_W-1:0]   op_data
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       hit_key1, hit_key2, at_cmd;
  logic [7:0] code;
  mode_e      mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  nor_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .hit_key1 (hit_key1),
    .hit_key2 (hit_key2),
    .at_cmd   (at_cmd),
    .code     (code)
  );

  nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_key1  (hit_key1),
    .hit_key2  (hit_key2),
    .at_cmd    (at_cmd),
    .code      (code),
    .mode_o    (mode_w),
    .prog_o    (prog_start),
    .sect_o    (sect_erase_start),
    .chip_o    (chip_erase_start),
    .op_addr_o (op_addr),
    .op_data_o (op_data)
  );

  nor_rd_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .autosel     (mode_w == MODE_AUTOSEL),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .sector_prot (sector_prot),
    .rd_data     (rd_data)
  );

  assign mode = mode_w;
endmodule

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [18:0]  wr_addr;
  logic [15:0]  wr_data;
  logic         busy;
  logic [18:0]  rd_addr;
  logic [15:0]  array_rdata;
  logic [127:0] sector_prot;
  logic [15:0]  rd_data;
  logic [2:0]   mode;
  logic         prog_start, sect_erase_start, chip_erase_start;
  logic [18:0]  op_addr;
  logic [15:0]  op_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [2:0] c_pulse;
  logic [2:0] c_mode;

  always #2 clk = ~clk;

  nor_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .array_rdata(array_rdata), .sector_prot(sector_prot),
    .rd_data(rd_data), .mode(mode), .prog_start(prog_start),
    .sect_erase_start(sect_erase_start), .chip_erase_start(chip_erase_start),
    .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // one strobed write; captures outputs just after the edge that takes it
  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    c_pulse = {prog_start, sect_erase_start, chip_erase_start};
    c_mode  = mode;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h00555, 16'h00AA);
    wr(19'h002AA, 16'h0055);
  endtask

  task automatic pulse_gone(input string req);
    @(posedge clk); #1;
    chk(req, {prog_start, sect_erase_start, chip_erase_start}, 3'b000);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 mode", mode, 3'd0);
    chk("R1 pulses", {prog_start, sect_erase_start, chip_erase_start}, 3'b000);
    chk("R1 rd_data", rd_data, array_rdata);
  endtask

  task automatic t_prog_std();
    // R2: upper address bits and upper data byte set on unlock and command writes
    wr(19'h7F555, 16'h12AA);
    wr(19'h452AA, 16'hFF55);
    wr(19'h1D555, 16'h33A0);
    wr(19'h12345, 16'hBEEF);
    chk("R3 prog pulse", c_pulse, 3'b100);
    chk("R3 op_addr", op_addr, 19'h12345);
    chk("R3 op_data", op_data, 16'hBEEF);
    chk("R3 mode", c_mode, 3'd0);
    pulse_gone("R12 prog one cycle");
  endtask

  task automatic t_autosel();
    unlock();
    wr(19'h00555, 16'h0090);
    chk("R4 enter autoselect", c_mode, 3'd1);
    rd_addr = 19'h00001; #1;
    chk("R5 device id", rd_data, 16'h225B);
    rd_addr = (19'd5 << 12) | 19'h2; #1;
    chk("R5 protected sector", rd_data, 16'h0001);
    rd_addr = (19'd6 << 12) | 19'h2; #1;
    chk("R5 unprotected sector", rd_data, 16'h0000);
    rd_addr = 19'h00003; #1;
    chk("R5 other offset", rd_data, 16'h0000);
    wr(19'h0ABCD, 16'h00F0);
    chk("R4 reset to read", c_mode, 3'd0);
    rd_addr = 19'h00001; #1;
    chk("R5 array outside autoselect", rd_data, array_rdata);
  endtask

  task automatic t_chip();
    unlock(); wr(19'h00555, 16'h0080); unlock();
    wr(19'h00555, 16'h0010);
    chk("R6 chip pulse", c_pulse, 3'b001);
    pulse_gone("R12 chip one cycle");
  endtask

  task automatic t_sector();
    unlock(); wr(19'h00555, 16'h0080); unlock();
    wr(19'h23000, 16'h0030);
    busy = 1'b1;
    chk("R7 sector pulse", c_pulse, 3'b010);
    chk("R7 op_addr", op_addr, 19'h23000);
    chk("R7 mode", c_mode, 3'd3);
    pulse_gone("R12 sector one cycle");
    wr(19'h00000, 16'h00B0);
    chk("R11 suspend", c_mode, 3'd4);
    wr(19'h00000, 16'h00B0);
    chk("R11 second suspend ignored", c_mode, 3'd4);
    wr(19'h00000, 16'h0030);
    chk("R11 resume", c_mode, 3'd3);
    @(negedge clk); busy = 1'b0;
    @(posedge clk); #1;
    chk("R11 erase end", mode, 3'd0);
  endtask

  task automatic t_susp_ignored();
    wr(19'h00000, 16'h00B0);
    chk("R11 suspend ignored in read", c_mode, 3'd0);
    wr(19'h00000, 16'h0030);
    chk("R11 resume ignored in read", {c_pulse, c_mode}, 6'd0);
  endtask

  task automatic t_bypass();
    unlock();
    wr(19'h00555, 16'h0020);
    chk("R8 enter bypass", c_mode, 3'd2);
    wr(19'h7FFFF, 16'h00A0);
    wr(19'h00444, 16'h5A5A);
    chk("R8 bypass prog", c_pulse, 3'b100);
    chk("R8 bypass op_data", op_data, 16'h5A5A);
    chk("R8 stays bypass", c_mode, 3'd2);
    wr(19'h00000, 16'h0090);
    wr(19'h00000, 16'h0055);
    chk("R8 bad exit stays bypass", c_mode, 3'd2);
    wr(19'h00000, 16'h0090);
    wr(19'h00000, 16'h0000);
    chk("R8 exit bypass", c_mode, 3'd0);
  endtask

  task automatic t_abort();
    wr(19'h00555, 16'h00AA);
    wr(19'h002AB, 16'h0055);   // wrong address
    wr(19'h00555, 16'h0090);
    chk("R9 broken unlock no autoselect", c_mode, 3'd0);
    unlock(); wr(19'h00555, 16'h0080); unlock();
    wr(19'h00556, 16'h0010);   // wrong address for chip erase
    chk("R9 broken erase no pulse", {c_pulse, c_mode}, 6'd0);
    unlock(); wr(19'h00555, 16'h0090);
    wr(19'h00555, 16'h00AA);
    wr(19'h00555, 16'h0055);   // wrong step from autoselect
    chk("R9 abort leaves autoselect", c_mode, 3'd0);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    unlock(); wr(19'h00555, 16'h00A0);
    wr(19'h00100, 16'h1111);
    chk("R10 busy blocks program", c_pulse, 3'b000);
    unlock(); wr(19'h00555, 16'h0090);
    chk("R10 busy blocks autoselect", c_mode, 3'd0);
    busy = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0;
    rd_addr = '0; array_rdata = 16'hC3A5;
    sector_prot = '0; sector_prot[5] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_prog_std();
    t_autosel();
    t_chip();
    t_sector();
    t_susp_ignored();
    t_bypass();
    t_abort();
    t_busy();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    summary();
  end
endmodule